// File: doc/BRIEF.md
# I2C Byte Engine with Acknowledge Control

This block moves single bytes across a two-wire I2C bus. It watches a synchronized SCL/SDA pair, finds START and STOP conditions, counts bit clocks and shifts data MSB first. It works as master or slave and as transmitter or receiver. It only ever pulls SDA low or lets it float, through one pull-low output. A separate generator supplies the SCL waveform. The engine tells that generator when the current clock is the acknowledge clock, so a master can add that ninth clock.

As a slave, the first byte after a START is an address byte. Its upper seven bits are compared with a programmable own address, and the all-zero byte is recognised as a general call. The engine acknowledges only when the address matches or a general call arrives. If neither happens, it stays silent until the next START or STOP. After it has been selected, the direction input decides whether the slave sends data and reads the master's acknowledge, or receives data and acknowledges it. A mode input turns the acknowledge clock off completely, and bytes then take exactly eight clocks.

Top module: `i2c_byte_engine`

## Requirements
- R1: A START (SDA falling while SCL is high) sets `bus_busy_o`, clears `addr_match_o` and `gen_call_o` and restarts the bit count, also in the middle of a byte. A STOP (SDA rising while SCL is high) clears `bus_busy_o` and releases SDA.
- R2: Bits are sampled on SCL rising edges, MSB first. After the eighth bit of an accepted byte, `rx_byte_o` holds that byte and `byte_done_o` pulses for one cycle.
- R3: As a transmitter, the engine puts `tx_byte_i` on SDA MSB first (`sda_pull_o`=1 for a 0 bit) and changes the pull only while SCL is low.
- R4: As a slave in acknowledge mode, an address byte whose bits [7:1] equal `own_addr_i` sets `addr_match_o` and pulls SDA low during the acknowledge clock.
- R5: As a slave, the address byte 8'h00 (address zero, R/W bit 0) sets `gen_call_o` and is acknowledged. Address zero with R/W 1 is not a general call.
- R6: As a slave, an address that matches neither case is not acknowledged. SDA stays released for the rest of the transfer, and `rx_byte_o` and `byte_done_o` do not change until the next START.
- R7: As a receiver in acknowledge mode (a master receiver, or a selected slave with `xmit_i`=0), the engine pulls SDA low during each data-byte acknowledge clock.
- R8: As a transmitter, the engine releases SDA during the acknowledge clock and latches the SDA level sampled at its rising edge into `rx_ack_bit_o` (0 = ACK). The reset value is 1.
- R9: With `ack_mode_i`=0, every byte is exactly eight clocks. The next clock carries the next byte's MSB, `ack_slot_o` never rises and no acknowledge is driven.
- R10: `ack_slot_o` is high from the SCL rise that completes the eighth bit until the next SCL rise, and only in acknowledge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| xmit_i | input | 1 | 1 = transmit data bytes, 0 = receive |
| ack_mode_i | input | 1 | 1 = nine-clock bytes with acknowledge, 0 = eight-clock bytes |
| own_addr_i | input | ADDR_W | Own slave address |
| tx_byte_i | input | DATA_W | Byte to transmit |
| rx_byte_o | output | DATA_W | Last accepted byte |
| byte_done_o | output | 1 | One-cycle pulse when a byte is accepted |
| ack_slot_o | output | 1 | Current clock is the acknowledge clock |
| bus_busy_o | output | 1 | Between START and STOP |
| addr_match_o | output | 1 | Own address was received |
| gen_call_o | output | 1 | General call was received |
| rx_ack_bit_o | output | 1 | Last acknowledge level read as transmitter |

## Verification
On the SCL rise that samples the last address bit, one clock edge does four things: it updates the address-match and general-call flags, switches the engine into the data phase or into the silent phase, and arms the acknowledge pull. The bench provokes this with address bytes that differ only in that last bit (8'h00 against 8'h01), and with random addresses that equal the own address about half the time. It judges the outcome on the bus itself: it samples SDA during the acknowledge clock, compares the flags, and compares `rx_byte_o` with the value a bench function predicts.

// File: rtl/ibe_pkg.sv
package ibe_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } ibe_phase_e;
endpackage

// File: rtl/ibe_line_events.sv
module ibe_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   // SDA moving while SCL stays high marks a bus condition
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ibe_bit_seq.sv
module ibe_bit_seq #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic             ack_mode_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_bit_o,
   output logic             ack_pos_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ACKP = CNT_W'(DATA_W);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (cnt_q == LAST)      cnt_q <= ack_mode_i ? ACKP : '0;
         else if (cnt_q == ACKP) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o      = cnt_q;
   assign last_bit_o = (cnt_q == LAST);
   assign ack_pos_o  = (cnt_q == ACKP);

   assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ACKP);
   assert_no_ack_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !restart_i && !ack_mode_i && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/ibe_addr_match.sv
module ibe_addr_match #(
   parameter int ADDR_W = 7,
   parameter bit GC_EN  = 1'b1
) (
   input  logic [ADDR_W:0]   byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   output logic              own_hit_o,
   output logic              gcall_o
);
   assign own_hit_o = (byte_i[ADDR_W:1] == own_addr_i);

   generate
      if (GC_EN) begin : g_gcall
         assign gcall_o = (byte_i == '0);
      end else begin : g_no_gcall
         assign gcall_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import ibe_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter bit GC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              master_i,
   input  logic              xmit_i,
   input  logic              ack_mode_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              byte_done_o,
   output logic              ack_slot_o,
   output logic              bus_busy_o,
   output logic              addr_match_o,
   output logic              gen_call_o,
   output logic              rx_ack_bit_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("i2c_byte_engine: ADDR_W must be at least 1");
      end
      if (DATA_W != ADDR_W + 1) begin : g_bad_data_w
         $error("i2c_byte_engine: DATA_W must equal ADDR_W + 1");
      end
   endgenerate

   logic scl_rise, scl_fall, start_evt, stop_evt;
   logic [CNT_W-1:0] cnt;
   logic last_bit, ack_pos;
   logic own_hit, gcall, addr_hit;

   ibe_phase_e        phase_q;
   logic [DATA_W-1:0] sh_q, tx_sh_q, rx_byte_q, full_byte;
   logic busy_q, done_q, match_q, gc_q, ack_pend_q, byte_tx_q, rx_ack_q, pull_q;

   ibe_line_events i_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_evt),
      .stop_o     (stop_evt)
   );

   ibe_bit_seq #(.DATA_W(DATA_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (start_evt | stop_evt),
      .step_i     (scl_rise & busy_q),
      .ack_mode_i (ack_mode_i),
      .cnt_o      (cnt),
      .last_bit_o (last_bit),
      .ack_pos_o  (ack_pos)
   );

   assign full_byte = {sh_q[DATA_W-2:0], sda_i};

   ibe_addr_match #(.ADDR_W(ADDR_W), .GC_EN(GC_EN)) i_match (
      .byte_i     (full_byte),
      .own_addr_i (own_addr_i),
      .own_hit_o  (own_hit),
      .gcall_o    (gcall)
   );

   assign addr_hit = own_hit | gcall;

   // Receive side: phase, shift register, flags, acknowledge bookkeeping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         busy_q     <= 1'b0;
         sh_q       <= '0;
         rx_byte_q  <= '0;
         done_q     <= 1'b0;
         match_q    <= 1'b0;
         gc_q       <= 1'b0;
         ack_pend_q <= 1'b0;
         byte_tx_q  <= 1'b0;
         rx_ack_q   <= 1'b1;
      end else begin
         done_q <= 1'b0;
         if (stop_evt) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            match_q <= 1'b0;
            gc_q    <= 1'b0;
         end else if (start_evt) begin
            phase_q <= master_i ? PH_DATA : PH_ADDR;
            busy_q  <= 1'b1;
            match_q <= 1'b0;
            gc_q    <= 1'b0;
         end else if (scl_rise && busy_q) begin
            if (!ack_pos) sh_q <= full_byte;
            if (ack_pos && byte_tx_q) rx_ack_q <= sda_i;
            if (last_bit) begin
               ack_pend_q <= 1'b0;
               byte_tx_q  <= 1'b0;
               case (phase_q)
                  PH_ADDR: begin
                     match_q <= own_hit;
                     gc_q    <= gcall;
                     if (addr_hit) begin
                        phase_q    <= PH_DATA;
                        rx_byte_q  <= full_byte;
                        done_q     <= 1'b1;
                        ack_pend_q <= ack_mode_i;
                     end else begin
                        phase_q <= PH_SKIP;
                     end
                  end
                  PH_DATA: begin
                     rx_byte_q  <= full_byte;
                     done_q     <= 1'b1;
                     ack_pend_q <= ack_mode_i & ~xmit_i;
                     byte_tx_q  <= xmit_i;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // Drive side: SDA pull changes on SCL falling edges only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_q  <= 1'b0;
         tx_sh_q <= '0;
      end else if (start_evt || stop_evt) begin
         pull_q <= 1'b0;
      end else if (scl_fall && busy_q) begin
         if (ack_pos) begin
            pull_q <= ack_pend_q;
         end else if (phase_q == PH_DATA && xmit_i) begin
            if (cnt == '0) begin
               pull_q  <= ~tx_byte_i[DATA_W-1];
               tx_sh_q <= tx_byte_i << 1;
            end else begin
               pull_q  <= ~tx_sh_q[DATA_W-1];
               tx_sh_q <= tx_sh_q << 1;
            end
         end else begin
            pull_q <= 1'b0;
         end
      end
   end

   assign sda_pull_o   = pull_q;
   assign rx_byte_o    = rx_byte_q;
   assign byte_done_o  = done_q;
   assign ack_slot_o   = ack_pos & busy_q;
   assign bus_busy_o   = busy_q;
   assign addr_match_o = match_q;
   assign gen_call_o   = gc_q;
   assign rx_ack_bit_o = rx_ack_q;

   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy_o |-> !sda_pull_o);
   assert_done_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_o |-> bus_busy_o);
   assert_pull_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !$past(scl_i));
   assert_skip_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SKIP) |-> (!sda_pull_o && !byte_done_o));
   assert_ack_latch_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_ack_bit_o) |-> $past(ack_slot_o));
   assert_slot_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_slot_o) |-> $past(ack_mode_i));
endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       master, xmit, ack_mode;
   logic [6:0] own_addr;
   logic [7:0] tx_byte;
   logic [7:0] rx_byte;
   logic       sda_pull, byte_done, ack_slot, busy, addr_match, gen_call, rx_ack_bit;
   wire        sda_bus = sda_m & ~sda_pull;

   int n_chk = 0, n_fail = 0, done_cnt = 0, slot_cnt = 0;
   bit reported = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_byte_engine i_i2c_byte_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_bus),
      .sda_pull_o   (sda_pull),
      .master_i     (master),
      .xmit_i       (xmit),
      .ack_mode_i   (ack_mode),
      .own_addr_i   (own_addr),
      .tx_byte_i    (tx_byte),
      .rx_byte_o    (rx_byte),
      .byte_done_o  (byte_done),
      .ack_slot_o   (ack_slot),
      .bus_busy_o   (busy),
      .addr_match_o (addr_match),
      .gen_call_o   (gen_call),
      .rx_ack_bit_o (rx_ack_bit)
   );

   always @(posedge clk) begin
      if (byte_done) done_cnt++;
      if (ack_slot)  slot_cnt++;
   end

   function automatic bit exp_hit(input logic [6:0] own, input logic [6:0] a, input logic rw);
      return (a == own) || ({a, rw} == 8'h00);
   endfunction

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk_eq(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic r);
      wait_n(2); sda_m = b;
      wait_n(2); scl = 1'b1;
      wait_n(2); r = sda_bus;
      wait_n(2); scl = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic [7:0] seen);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         clk_bit(d[i], b);
         seen[i] = b;
      end
   endtask

   task automatic bus_start();
      if (!scl) begin
         wait_n(2); sda_m = 1'b1;
         wait_n(2); scl = 1'b1;
         wait_n(2);
      end
      sda_m = 1'b0; wait_n(2);
      scl = 1'b0;   wait_n(2);
   endtask

   task automatic bus_stop();
      wait_n(2); sda_m = 1'b0;
      wait_n(2); scl = 1'b1;
      wait_n(2); sda_m = 1'b1;
      wait_n(2);
   endtask

   // Slave receiver transfer: address byte (R/W=0), one data byte, STOP
   task automatic slave_rx_txn(input logic [6:0] own, input logic [6:0] a, input logic [7:0] d);
      logic [7:0] s, prev;
      logic ak;
      bit hit;
      int dc0;
      own_addr = own; master = 1'b0; xmit = 1'b0; ack_mode = 1'b1;
      prev = rx_byte; dc0 = done_cnt;
      hit = exp_hit(own, a, 1'b0);
      bus_start();
      chk_eq("R1", "busy after START", busy, 1);
      wr_byte({a, 1'b0}, s);
      clk_bit(1'b1, ak);
      chk_eq("R4", "address ack level", ak, !hit);
      chk_eq("R4", "match flag", addr_match, a == own);
      chk_eq("R5", "general call flag", gen_call, a == 7'h00);
      wr_byte(d, s);
      chk_eq("R6", "data bits on bus", s, d);
      clk_bit(1'b1, ak);
      chk_eq("R7", "data ack level", ak, !hit);
      chk_eq("R2", "received byte", rx_byte, hit ? d : prev);
      chk_eq("R6", "accepted byte count", done_cnt - dc0, hit ? 2 : 0);
      bus_stop();
      chk_eq("R1", "busy after STOP", busy, 0);
      chk_eq("R1", "flags after STOP", {addr_match, gen_call}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [7:0] s;
      logic ak;
      int dc0;
      master = 1'b0; xmit = 1'b0; ack_mode = 1'b1; own_addr = 7'h3A; tx_byte = 8'h00;
      void'($urandom(32'd1789));
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);

      // Reset state
      chk_eq("R1", "reset busy", busy, 0);
      chk_eq("R1", "reset pull", sda_pull, 0);
      chk_eq("R8", "reset rx ack bit", rx_ack_bit, 1);
      chk_eq("R10", "reset ack slot", ack_slot, 0);
      chk_eq("R2", "reset rx byte", rx_byte, 0);

      // Directed slave receiver cases
      slave_rx_txn(7'h3A, 7'h3A, 8'h5C);   // own address
      slave_rx_txn(7'h3A, 7'h00, 8'hE1);   // general call
      slave_rx_txn(7'h3A, 7'h3B, 8'h00);   // mismatch, zero data

      // R5: address zero with R/W 1 is not a general call
      own_addr = 7'h55;
      bus_start();
      wr_byte(8'h01, s);
      clk_bit(1'b1, ak);
      chk_eq("R5", "0x01 not acked", ak, 1);
      chk_eq("R5", "0x01 no general call", gen_call, 0);
      bus_stop();

      // R1/R10: repeated START mid-byte, ack slot window
      own_addr = 7'h62;
      bus_start();
      clk_bit(1'b1, ak); clk_bit(1'b1, ak); clk_bit(1'b0, ak);
      bus_start();
      wr_byte({7'h62, 1'b0}, s);
      chk_eq("R10", "ack slot during ninth clock", ack_slot, 1);
      clk_bit(1'b1, ak);
      chk_eq("R1", "ack after restarted address", ak, 0);
      chk_eq("R10", "ack slot after ninth clock", ack_slot, 0);
      chk_eq("R1", "match after restart", addr_match, 1);
      bus_stop();

      // R3/R8: slave transmitter
      own_addr = 7'h2C; xmit = 1'b1; tx_byte = 8'hA5;
      bus_start();
      wr_byte({7'h2C, 1'b1}, s);
      clk_bit(1'b1, ak);
      chk_eq("R4", "slave tx address ack", ak, 0);
      rd_check: begin
         wr_byte(8'hFF, s);
         chk_eq("R3", "slave tx byte 1", s, 8'hA5);
      end
      tx_byte = 8'h3C;
      clk_bit(1'b0, ak);
      chk_eq("R8", "latched ACK", rx_ack_bit, 0);
      wr_byte(8'hFF, s);
      chk_eq("R3", "slave tx byte 2", s, 8'h3C);
      xmit = 1'b0;
      clk_bit(1'b1, ak);
      chk_eq("R8", "released on ack clock", ak, 1);
      chk_eq("R8", "latched NACK", rx_ack_bit, 1);
      bus_stop();

      // R3/R8: master transmitter
      master = 1'b1; xmit = 1'b1; tx_byte = 8'h96;
      bus_start();
      wr_byte(8'hFF, s);
      chk_eq("R3", "master tx byte", s, 8'h96);
      xmit = 1'b0;
      clk_bit(1'b0, ak);
      chk_eq("R8", "master latched ACK", rx_ack_bit, 0);
      bus_stop();

      // R7: master receiver
      bus_start();
      wr_byte(8'h4B, s);
      clk_bit(1'b1, ak);
      chk_eq("R7", "master receiver ack", ak, 0);
      chk_eq("R2", "master received byte", rx_byte, 8'h4B);
      bus_stop();

      // R9: non-acknowledge mode, eight-clock bytes
      master = 1'b0; ack_mode = 1'b0; own_addr = 7'h11;
      slot_cnt = 0; dc0 = done_cnt;
      bus_start();
      wr_byte({7'h11, 1'b0}, s);
      chk_eq("R9", "address bits unpulled", s, {7'h11, 1'b0});
      wr_byte(8'hC3, s);
      chk_eq("R9", "data follows at clock nine", s, 8'hC3);
      chk_eq("R9", "received byte", rx_byte, 8'hC3);
      chk_eq("R9", "match flag", addr_match, 1);
      chk_eq("R9", "bytes accepted", done_cnt - dc0, 2);
      chk_eq("R10", "no ack slot", slot_cnt, 0);
      bus_stop();

      // Random slave receiver transfers
      for (int it = 0; it < 30; it++) begin
         logic [6:0] own, a;
         logic [7:0] d;
         own = 7'($urandom());
         a   = ($urandom() % 2) ? own : 7'($urandom());
         if ($urandom() % 8 == 0) a = 7'h00;
         d   = 8'($urandom());
         slave_rx_txn(own, a, d);
      end

      report();
   end
endmodule